// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer

This block holds five down-counters behind a small register bus. Channels 0 to 3 each drive one PWM pin; channel 4 is a plain interval timer with no pin. Software loads a period value (and, for the PWM channels, a threshold value) into buffer registers. Those buffers reach the live counter only at two moments: while the channel's load bit is held in the control register, or when a running counter with repeat mode enabled hits zero and reloads itself.

Every channel has a count enable derived from a shared 8-bit prescaler and a per-channel power-of-two divider. Channels 0 and 1 share one prescaler; channels 2, 3 and 4 share the other. A PWM pin is high while its counter is above its threshold. Software therefore writes the threshold as the period value minus the wanted high ticks. Each channel pulses a one-cycle flag when its running counter steps from 1 to 0.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads zero, all PWM pins are low and no zero flag is set.
- R2: Writing a period or threshold buffer leaves the live counter unchanged; the observation slot keeps its old value.
- R3: While a channel's load bit is set, its live counter takes its period buffer (and its threshold buffer) on every clock, and it does not count.
- R4: A counting channel decrements once every (P+1)*2^D clocks, where P is its group prescaler and D its 4-bit divider field (nibble n of the divider register at 0x04 belongs to channel n).
- R5: The prescaler register at 0x00 is split: bits [7:0] pace channels 0 and 1, and bits [15:8] pace channels 2, 3 and 4.
- R6: A PWM pin is high exactly while the counter is above the threshold. With repeat mode, period value N and threshold C, each cycle lasts N+1 ticks, with N-C of them high.
- R7: The invert bit complements a PWM channel's pin.
- R8: In repeat mode, a counter at zero reloads from the current buffers on its next tick, so new buffer values take effect from the following cycle.
- R9: Without repeat mode, a counter reaching zero stays at zero and flags exactly once.
- R10: The zero flag is high for one clock, on the cycle the live counter first shows 0 after stepping down from 1.
- R11: Channel 4 has only a period buffer (0x3C). Its threshold slot (0x40) ignores writes and reads zero. Loaded with all ones, it counts down from the full count.
- R12: With its run bit clear, a channel's live counter holds its value.
- R13: Control register at 0x08: channel n<4 has run at bit 4n, load 4n+1, invert 4n+2, repeat 4n+3. Channel 4 has run at bit 20, load 21, repeat 22. Unused bits read zero. Channel n's period buffer is at 0x0C+12n, its threshold buffer at 0x10+12n, and a read-only view of its live counter at 0x14+12n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | PWM pins of channels 0 to 3 |
| zero_pulse | output | 5 | One-cycle zero flag per channel |

## Verification
The hardest situation to reach from the ports is a buffer change that lands while a channel is already cycling in repeat mode. The new values must not disturb the cycle in progress and must take over cleanly at the next reload. The bench gets there by starting channel 1 in repeat mode and letting one full cycle pass. It then rewrites both buffers mid-run, discards the cycle in flight, and measures the following cycle's length and high time between two zero flags. Prescaler grouping is separated by running three channels at once with different divider and prescaler choices, so each one's flag spacing proves which prescaler paced it.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    localparam int PRE_GROUPS  = 2;   // number of shared prescalers
    localparam int GRP0_LIMIT  = 2;   // channels below this index use prescaler 0
    localparam int A_PRESCALE  = 'h00;
    localparam int A_DIVSEL    = 'h04;
    localparam int A_CONTROL   = 'h08;
    localparam int SLOT_BASE   = 'h0C;
    localparam int SLOT_STRIDE = 12;
    localparam int OFS_PERIOD  = 0;
    localparam int OFS_THRESH  = 4;
    localparam int OFS_VIEW    = 8;
endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= limit);
        cnt_d = tick ? '0 : cnt_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan #(
    parameter int CNT_W     = 16,
    parameter int DIV_SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pre_tick,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 run,
    input  logic                 load,
    input  logic                 repeat_en,
    input  logic [CNT_W-1:0]     buf_cnt,
    input  logic [CNT_W-1:0]     buf_cmp,
    output logic [CNT_W-1:0]     cnt,
    output logic [CNT_W-1:0]     cmp,
    output logic                 zero
);
    localparam int DIVC_W = (1 << DIV_SEL_W) - 1;

    typedef struct packed {
        logic [DIVC_W-1:0] div;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
        logic              zero;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [DIVC_W-1:0] mask;
    logic              tick;

    always_comb begin
        mask = (DIVC_W'(1) << div_sel) - DIVC_W'(1);
        tick = pre_tick && ((st_q.div & mask) == mask);
        st_d      = st_q;
        st_d.zero = 1'b0;
        if (pre_tick) st_d.div = st_q.div + DIVC_W'(1);
        if (load) begin
            st_d.cnt = buf_cnt;
            st_d.cmp = buf_cmp;
        end else if (run && tick) begin
            if (st_q.cnt != '0) begin
                st_d.cnt  = st_q.cnt - CNT_W'(1);
                st_d.zero = (st_q.cnt == CNT_W'(1));
            end else if (repeat_en) begin
                st_d.cnt = buf_cnt;
                st_d.cmp = buf_cmp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign cmp  = st_q.cmp;
    assign zero = st_q.zero;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
    parameter int NPWM      = 4,
    parameter int CNT_W     = 16,
    parameter int PRE_W     = 8,
    parameter int DIV_SEL_W = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPWM-1:0]   pwm_out,
    output logic [NPWM:0]     zero_pulse
);
    import pwmt_pkg::*;

    localparam int NCH     = NPWM + 1;
    localparam int TMR     = NPWM;
    localparam int TMR_POS = 4 * NPWM + 4;

    typedef struct packed {
        logic [PRE_GROUPS*PRE_W-1:0]     prescale;
        logic [NCH*DIV_SEL_W-1:0]        divsel;
        logic [NCH-1:0]                  run;
        logic [NCH-1:0]                  load;
        logic [NCH-1:0]                  rpt;
        logic [NPWM-1:0]                 inv;
        logic [NCH-1:0][CNT_W-1:0]       pbuf;
        logic [NPWM-1:0][CNT_W-1:0]      tbuf;
    } regs_t;

    function automatic logic [ADDR_W-1:0] slot(input int ch, input int ofs);
        return ADDR_W'(SLOT_BASE + SLOT_STRIDE * ch + ofs);
    endfunction

    regs_t regs_d, regs_q;
    logic [NCH-1:0]            run_en, upd_en, rel_en;
    logic [NPWM-1:0]           inv_en;
    logic [NCH-1:0][CNT_W-1:0] cbuf_q;
    logic [NPWM-1:0][CNT_W-1:0] tbuf_q;
    logic [NCH-1:0][CNT_W-1:0] cnt_act, cmp_act;
    logic [PRE_GROUPS-1:0]     pre_tick;

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(A_PRESCALE))
                regs_d.prescale = bus_wdata[PRE_GROUPS*PRE_W-1:0];
            if (bus_addr == ADDR_W'(A_DIVSEL))
                regs_d.divsel = bus_wdata[NCH*DIV_SEL_W-1:0];
            if (bus_addr == ADDR_W'(A_CONTROL)) begin
                for (int i = 0; i < NPWM; i++) begin
                    regs_d.run[i]  = bus_wdata[4*i];
                    regs_d.load[i] = bus_wdata[4*i+1];
                    regs_d.inv[i]  = bus_wdata[4*i+2];
                    regs_d.rpt[i]  = bus_wdata[4*i+3];
                end
                regs_d.run[TMR]  = bus_wdata[TMR_POS];
                regs_d.load[TMR] = bus_wdata[TMR_POS+1];
                regs_d.rpt[TMR]  = bus_wdata[TMR_POS+2];
            end
            for (int i = 0; i < NCH; i++)
                if (bus_addr == slot(i, OFS_PERIOD)) regs_d.pbuf[i] = bus_wdata[CNT_W-1:0];
            for (int i = 0; i < NPWM; i++)
                if (bus_addr == slot(i, OFS_THRESH)) regs_d.tbuf[i] = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_PRESCALE)) bus_rdata = DATA_W'(regs_q.prescale);
        if (bus_addr == ADDR_W'(A_DIVSEL))   bus_rdata = DATA_W'(regs_q.divsel);
        if (bus_addr == ADDR_W'(A_CONTROL)) begin
            for (int i = 0; i < NPWM; i++) begin
                bus_rdata[4*i]   = regs_q.run[i];
                bus_rdata[4*i+1] = regs_q.load[i];
                bus_rdata[4*i+2] = regs_q.inv[i];
                bus_rdata[4*i+3] = regs_q.rpt[i];
            end
            bus_rdata[TMR_POS]   = regs_q.run[TMR];
            bus_rdata[TMR_POS+1] = regs_q.load[TMR];
            bus_rdata[TMR_POS+2] = regs_q.rpt[TMR];
        end
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == slot(i, OFS_PERIOD)) bus_rdata = DATA_W'(regs_q.pbuf[i]);
            if (bus_addr == slot(i, OFS_VIEW))   bus_rdata = DATA_W'(cnt_act[i]);
        end
        for (int i = 0; i < NPWM; i++)
            if (bus_addr == slot(i, OFS_THRESH)) bus_rdata = DATA_W'(regs_q.tbuf[i]);
        // the interval timer's threshold slot shows its live threshold, held at zero
        if (bus_addr == slot(TMR, OFS_THRESH)) bus_rdata = DATA_W'(cmp_act[TMR]);
    end

    assign run_en = regs_q.run;
    assign upd_en = regs_q.load;
    assign rel_en = regs_q.rpt;
    assign inv_en = regs_q.inv;
    assign cbuf_q = regs_q.pbuf;
    assign tbuf_q = regs_q.tbuf;

    for (genvar p = 0; p < PRE_GROUPS; p++) begin : g_pre
        pwmt_prescale #(.PRE_W(PRE_W)) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .limit (regs_q.prescale[p*PRE_W +: PRE_W]),
            .tick  (pre_tick[p])
        );
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CNT_W-1:0] cmp_src;
        if (g < NPWM) begin : g_pwm
            assign cmp_src    = tbuf_q[g];
            assign pwm_out[g] = (cnt_act[g] > cmp_act[g]) ^ inv_en[g];
        end else begin : g_tmr
            assign cmp_src = '0;
        end
        pwmt_chan #(.CNT_W(CNT_W), .DIV_SEL_W(DIV_SEL_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .pre_tick  (pre_tick[(g < GRP0_LIMIT) ? 0 : 1]),
            .div_sel   (regs_q.divsel[g*DIV_SEL_W +: DIV_SEL_W]),
            .run       (run_en[g]),
            .load      (upd_en[g]),
            .repeat_en (rel_en[g]),
            .buf_cnt   (cbuf_q[g]),
            .buf_cmp   (cmp_src),
            .cnt       (cnt_act[g]),
            .cmp       (cmp_act[g]),
            .zero      (zero_pulse[g])
        );
    end
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
    parameter int NCH   = 5,
    parameter int NPWM  = 4,
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            run_en,
    input logic [NCH-1:0]            upd_en,
    input logic [NCH-1:0]            rel_en,
    input logic [NPWM-1:0]           inv_en,
    input logic [NCH-1:0][CNT_W-1:0] cnt,
    input logic [NCH-1:0][CNT_W-1:0] cbuf,
    input logic [NCH-1:0]            zero,
    input logic [NPWM-1:0]           pwm
);
    for (genvar i = 0; i < NCH; i++) begin : g_c
        // R3
        load_copies_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            upd_en[i] |=> cnt[i] == $past(cbuf[i]));
        // R12
        halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_en[i] && !upd_en[i]) |=> $stable(cnt[i]));
        // R9
        oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run_en[i] && !upd_en[i] && !rel_en[i] && cnt[i] == '0) |=> cnt[i] == '0);
        // R10
        zero_at_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
            zero[i] |-> cnt[i] == '0);
        // R10
        zero_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            zero[i] |=> !zero[i]);
    end
    for (genvar i = 0; i < NPWM; i++) begin : g_p
        // R6
        idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[i] == '0 && !inv_en[i]) |-> !pwm[i]);
    end
endmodule

bind pwm_timer pwmt_checker #(.NCH(NCH), .NPWM(NPWM), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .upd_en (upd_en),
    .rel_en (rel_en),
    .inv_en (inv_en),
    .cnt    (cnt_act),
    .cbuf   (cbuf_q),
    .zero   (zero_pulse),
    .pwm    (pwm_out)
);

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    logic [4:0]  zero_pulse;
    int n_chk = 0;
    int n_fail = 0;

    pwm_timer u_pwm_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .zero_pulse(zero_pulse)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        int guard = 0;
        per = 0; hi = 0;
        do begin @(negedge clk); guard++; end while (!zero_pulse[ch] && guard < 4000);
        do begin
            if (ch < 4 && pwm_out[ch % 4]) hi++;
            per++;
            @(negedge clk);
        end while (!zero_pulse[ch] && per < 4000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(8'h00, v); chk("R1 prescale", v, 0);
        rd(8'h04, v); chk("R1 divsel", v, 0);
        rd(8'h08, v); chk("R1 control", v, 0);
        rd(8'h14, v); chk("R1 view0", v, 0);
        chk("R1 pwm", pwm_out, 0);
        chk("R1 zero", zero_pulse, 0);
    endtask

    task automatic t_buffers();
        logic [31:0] v;
        do_reset();
        wr(8'h0C, 32'h55);
        rd(8'h14, v); chk("R2 view unchanged", v, 0);
        rd(8'h0C, v); chk("R13 period readback", v, 32'h55);
        wr(8'h08, 32'h2);
        rd(8'h14, v); chk("R3 load copies", v, 32'h55);
        wr(8'h0C, 32'h66);
        rd(8'h14, v); chk("R3 load level", v, 32'h66);
    endtask

    task automatic t_rates();
        int per, hi;
        do_reset();
        wr(8'h00, 32'h0102);
        wr(8'h04, 32'h201);
        wr(8'h0C, 32'd3);
        wr(8'h24, 32'd1);
        wr(8'h3C, 32'd1);
        wr(8'h08, 32'h0020_0202);
        wr(8'h08, 32'h0050_0909);
        measure(0, per, hi); chk("R4 ch0 period", per, 24);
        measure(2, per, hi); chk("R5 ch2 period", per, 16);
        measure(4, per, hi); chk("R5 ch4 period", per, 4);
    endtask

    task automatic t_pwm();
        int per, hi;
        do_reset();
        wr(8'h18, 32'd9);
        wr(8'h1C, 32'd6);
        wr(8'h08, 32'h20);
        wr(8'h08, 32'h90);
        measure(1, per, hi);
        chk("R6 period", per, 10);
        chk("R6 high", hi, 3);
        wr(8'h08, 32'hD0);
        measure(1, per, hi);
        chk("R7 inverted high", hi, 7);
        wr(8'h08, 32'h90);
        wr(8'h18, 32'd4);
        wr(8'h1C, 32'd1);
        measure(1, per, hi);
        measure(1, per, hi);
        chk("R8 new period", per, 5);
        chk("R8 new high", hi, 3);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        int pulses = 0;
        do_reset();
        wr(8'h30, 32'd5);
        wr(8'h08, 32'h2000);
        wr(8'h08, 32'h1000);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (zero_pulse[3]) pulses++;
        end
        chk("R9 R10 single flag", pulses, 1);
        rd(8'h38, v); chk("R9 rests at zero", v, 0);
        chk("R9 pin low", pwm_out[3], 0);
    endtask

    task automatic t_halt();
        logic [31:0] a, b;
        do_reset();
        wr(8'h30, 32'd100);
        wr(8'h08, 32'h2000);
        wr(8'h08, 32'h1000);
        repeat (10) @(negedge clk);
        wr(8'h08, 32'h0);
        rd(8'h38, a);
        repeat (20) @(negedge clk);
        rd(8'h38, b);
        chk("R12 held", b, a);
        chk("R12 had run", (a < 100) ? 1 : 0, 1);
    endtask

    task automatic t_timer();
        logic [31:0] v;
        do_reset();
        wr(8'h40, 32'h1234);
        rd(8'h40, v); chk("R11 threshold slot", v, 0);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h3C, v); chk("R11 period width", v, 32'hFFFF);
        wr(8'h08, 32'h0020_0000);
        rd(8'h44, v); chk("R11 loaded", v, 32'hFFFF);
        wr(8'h08, 32'h0010_0000);
        repeat (10) @(negedge clk);
        rd(8'h44, v);
        chk("R11 counting down", (v < 32'hFFFF && v > 32'hFFEB) ? 1 : 0, 1);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        do_reset();
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R13 control mask", v, 32'h0070_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R13 prescale mask", v, 32'hFFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R13 divsel mask", v, 32'hF_FFFF);
    endtask

    initial begin
        t_reset();
        t_buffers();
        t_rates();
        t_pwm();
        t_oneshot();
        t_halt();
        t_timer();
        t_regs();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #600000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule